// File: doc/BRIEF.md
# Cascaded Active-Address Bus Arbiter

Several content-addressable memory devices share one active-address output bus. They sit in a priority chain: device 0 has the highest priority, and one device per chain is configured as the lowest-priority end. Each device holds one copy of this block. The block remembers which kind of control cycle last updated the active address: a search, an access to the highest-priority entry, a write into the next free location, a read or a write. From that cycle it decides whether this device drives its own address, drives all ones on behalf of the whole chain, or leaves the bus released.

The choice of driver comes from chain position, not from the output enable. Two chain signals carry the state of the devices above. One says a match has already been found upstream. The other says a free location has already been found upstream. Each device combines them with its local results and passes them on. A device that is not chosen never drives, whatever its output enable says. The chosen device drives only while its output enable is high. The selection and the address are captured on the clock edge that ends the cycle, and the bus output follows from the next cycle on.

Top module: `aab_arbiter`

## Requirements
- R1: After reset, `aa_drive` is 0 and `aa_value` is all zeros until a cycle code selects the device.
- R2: `cyc_kind` encodes 0 = none, 1 = search, 2 = highest-priority access, 3 = write at next free, 4 = read, 5 = write. Codes 0, 6 and 7 leave the selection and the address unchanged.
- R3: On a search or highest-priority access, a device with `loc_match`=1 and `up_match`=0 drives `loc_match_addr` from the following cycle.
- R4: On a search or highest-priority access, a device whose `up_match` is 1 does not drive, even when its own match is set.
- R5: On a search or highest-priority access where no device in the chain matches, only the device with `is_last`=1 drives, and it drives all ones.
- R6: On a write at next free, the first device in the chain that is not full (`loc_full`=0 with `up_free_seen`=0) drives `loc_free_addr`.
- R7: On a write at next free when every device is full, only the device with `is_last`=1 drives, and it drives all ones.
- R8: `aa_drive` equals the stored selection ANDed with `oe`. An unselected device never drives. `aa_value` reads zero whenever `aa_drive` is 0.
- R9: On a read (4) or write (5), the device is selected exactly when `loc_sel`=1, and it drives `rd_addr` or `wr_addr` respectively.
- R10: `dn_match` = `up_match` OR `loc_match`, and `dn_free_seen` = `up_free_seen` OR NOT `loc_full`. Both are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_kind | input | 3 | Control cycle code (see R2) |
| loc_match | input | 1 | Local search produced a match |
| loc_match_addr | input | ADDR_W | Local highest-priority match address |
| loc_full | input | 1 | Local array has no free location |
| loc_free_addr | input | ADDR_W | Local next free address |
| loc_sel | input | 1 | Read/write addresses this device |
| rd_addr | input | ADDR_W | Read address |
| wr_addr | input | ADDR_W | Write address |
| up_match | input | 1 | A match exists upstream |
| up_free_seen | input | 1 | A free location exists upstream |
| is_last | input | 1 | This device is the lowest-priority device |
| oe | input | 1 | Output enable |
| aa_value | output | ADDR_W | Active address (zero when not driving) |
| aa_drive | output | 1 | Bus drive enable |
| dn_match | output | 1 | Match chain to the next device |
| dn_free_seen | output | 1 | Free chain to the next device |

## Verification
The assertions check on every cycle that the drive enable never rises without the output enable. They also check that an upstream match or a full chain keeps a device off the bus, that the last device answers with all ones when nothing matched, that matching and read addresses appear one cycle after their cycle, and that idle codes hold the output. Only the bench's three-device chain can show that exactly one device drives in each situation. It also shows that priority passes correctly between real neighbours, and that the stored selection survives idle cycles while the output enable toggles.

// File: rtl/aab_pkg.sv
// Shared cycle codes and source tags for the active-address arbiter.
// Assumes the cycle code is three bits wide, as the requirements fix it.
package aab_pkg;

    localparam logic [2:0] CK_NONE      = 3'd0;
    localparam logic [2:0] CK_COMPARE   = 3'd1;
    localparam logic [2:0] CK_HP_ACCESS = 3'd2;
    localparam logic [2:0] CK_WR_FREE   = 3'd3;
    localparam logic [2:0] CK_READ      = 3'd4;
    localparam logic [2:0] CK_WRITE     = 3'd5;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_MATCH = 3'd1,
        SRC_FREE  = 3'd2,
        SRC_READ  = 3'd3,
        SRC_WRITE = 3'd4
    } aa_src_e;

    // True for cycle codes that resolve through the match chain.
    function automatic logic is_search_kind(input logic [2:0] k);
        return (k == CK_COMPARE) || (k == CK_HP_ACCESS);
    endfunction

endpackage

// File: rtl/aab_chain_link.sv
// Chain link: combines the upstream chain flags with the local results.
// Produces the downstream flags and the per-device win conditions.
// Assumes device 0 gets both upstream flags tied low.
module aab_chain_link (
    input  logic up_match,
    input  logic loc_match,
    input  logic up_free_seen,
    input  logic loc_full,
    output logic dn_match,
    output logic dn_free_seen,
    output logic match_win,
    output logic free_win,
    output logic chain_no_match,
    output logic chain_full
);
    // Purpose: propagate the chain flags and derive the local win terms.
    always_comb begin
        dn_match       = up_match | loc_match;
        dn_free_seen   = up_free_seen | ~loc_full;
        match_win      = loc_match & ~up_match;
        free_win       = ~loc_full & ~up_free_seen;
        chain_no_match = ~(up_match | loc_match);
        chain_full     = ~(up_free_seen | ~loc_full);
    end
endmodule

// File: rtl/aab_select.sv
// Selection logic: for the current cycle code, decides whether the stored
// state updates, whether this device becomes the driver, and which value
// and source it will hold. Purely combinational.
module aab_select #(
    parameter int ADDR_W = 12
) (
    input  logic [2:0]        cyc_kind,
    input  logic              match_win,
    input  logic              free_win,
    input  logic              chain_no_match,
    input  logic              chain_full,
    input  logic              is_last,
    input  logic              loc_sel,
    input  logic [ADDR_W-1:0] loc_match_addr,
    input  logic [ADDR_W-1:0] loc_free_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              upd,
    output logic              nxt_sel,
    output logic [ADDR_W-1:0] nxt_val,
    output aab_pkg::aa_src_e  nxt_src
);
    import aab_pkg::*;
    localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

    // Purpose: choose the next driver state from the cycle code and chain position.
    always_comb begin
        upd     = 1'b1;
        nxt_sel = 1'b0;
        nxt_val = '0;
        nxt_src = SRC_NONE;
        if (is_search_kind(cyc_kind)) begin
            nxt_src = SRC_MATCH;
            if (match_win) begin
                nxt_sel = 1'b1;
                nxt_val = loc_match_addr;
            end else if (chain_no_match && is_last) begin
                nxt_sel = 1'b1;
                nxt_val = ALL_ONES;
            end
        end else if (cyc_kind == CK_WR_FREE) begin
            nxt_src = SRC_FREE;
            if (free_win) begin
                nxt_sel = 1'b1;
                nxt_val = loc_free_addr;
            end else if (chain_full && is_last) begin
                nxt_sel = 1'b1;
                nxt_val = ALL_ONES;
            end
        end else if (cyc_kind == CK_READ) begin
            nxt_src = SRC_READ;
            nxt_sel = loc_sel;
            nxt_val = rd_addr;
        end else if (cyc_kind == CK_WRITE) begin
            nxt_src = SRC_WRITE;
            nxt_sel = loc_sel;
            nxt_val = wr_addr;
        end else begin
            upd = 1'b0;
        end
    end
endmodule

// File: rtl/aab_drive_reg.sv
// Drive register: holds the selection, the address and its source, and
// gates the bus output with the output enable. Synchronous active-low reset.
module aab_drive_reg #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              nxt_sel,
    input  logic [ADDR_W-1:0] nxt_val,
    input  aab_pkg::aa_src_e  nxt_src,
    input  logic              oe,
    output logic [ADDR_W-1:0] aa_value,
    output logic              aa_drive
);
    import aab_pkg::*;
    logic              sel_q;
    logic [ADDR_W-1:0] val_q;
    aa_src_e           src_q;

    // Purpose: capture the decision of each updating cycle; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            val_q <= '0;
            src_q <= SRC_NONE;
        end else if (upd) begin
            sel_q <= nxt_sel;
            val_q <= nxt_val;
            src_q <= nxt_src;
        end
    end

    // Purpose: drive only when selected, with a known source, and enabled.
    always_comb begin
        aa_drive = sel_q && oe && (src_q != SRC_NONE);
        aa_value = aa_drive ? val_q : '0;
    end
endmodule

// File: rtl/aab_arbiter.sv
// Top of the per-device active-address arbiter. Wires the chain link,
// the selection logic and the drive register together. Assumes the
// chain flags of neighbours are connected dn_* -> up_*.
module aab_arbiter #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cyc_kind,
    input  logic              loc_match,
    input  logic [ADDR_W-1:0] loc_match_addr,
    input  logic              loc_full,
    input  logic [ADDR_W-1:0] loc_free_addr,
    input  logic              loc_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              up_match,
    input  logic              up_free_seen,
    input  logic              is_last,
    input  logic              oe,
    output logic [ADDR_W-1:0] aa_value,
    output logic              aa_drive,
    output logic              dn_match,
    output logic              dn_free_seen
);
    import aab_pkg::*;
    logic              match_win, free_win, chain_no_match, chain_full;
    logic              upd, nxt_sel;
    logic [ADDR_W-1:0] nxt_val;
    aa_src_e           nxt_src;

    aab_chain_link u_link (
        .up_match       (up_match),
        .loc_match      (loc_match),
        .up_free_seen   (up_free_seen),
        .loc_full       (loc_full),
        .dn_match       (dn_match),
        .dn_free_seen   (dn_free_seen),
        .match_win      (match_win),
        .free_win       (free_win),
        .chain_no_match (chain_no_match),
        .chain_full     (chain_full)
    );

    aab_select #(.ADDR_W(ADDR_W)) u_sel (
        .cyc_kind       (cyc_kind),
        .match_win      (match_win),
        .free_win       (free_win),
        .chain_no_match (chain_no_match),
        .chain_full     (chain_full),
        .is_last        (is_last),
        .loc_sel        (loc_sel),
        .loc_match_addr (loc_match_addr),
        .loc_free_addr  (loc_free_addr),
        .rd_addr        (rd_addr),
        .wr_addr        (wr_addr),
        .upd            (upd),
        .nxt_sel        (nxt_sel),
        .nxt_val        (nxt_val),
        .nxt_src        (nxt_src)
    );

    aab_drive_reg #(.ADDR_W(ADDR_W)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd),
        .nxt_sel  (nxt_sel),
        .nxt_val  (nxt_val),
        .nxt_src  (nxt_src),
        .oe       (oe),
        .aa_value (aa_value),
        .aa_drive (aa_drive)
    );
endmodule

// File: rtl/aab_arbiter_checker.sv
// Checker for aab_arbiter: port-level properties over time. Bound below.
module aab_arbiter_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cyc_kind,
    input logic              loc_match,
    input logic [ADDR_W-1:0] loc_match_addr,
    input logic              loc_full,
    input logic [ADDR_W-1:0] loc_free_addr,
    input logic              loc_sel,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              up_match,
    input logic              up_free_seen,
    input logic              is_last,
    input logic              oe,
    input logic [ADDR_W-1:0] aa_value,
    input logic              aa_drive,
    input logic              dn_match,
    input logic              dn_free_seen
);
    localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

    // R8: the bus is never driven without the output enable
    p_drive_needs_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        aa_drive |-> oe);

    // R8: no drive means the value reads zero
    p_idle_value_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !aa_drive |-> aa_value == '0);

    // R4: an upstream match keeps this device off the bus
    p_upstream_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 3'd1 || cyc_kind == 3'd2) && up_match |=> !aa_drive);

    // R3: the winning match address appears in the next cycle
    p_match_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 3'd1 || cyc_kind == 3'd2) && loc_match && !up_match
        |=> !oe || aa_value == $past(loc_match_addr));

    // R5: the last device answers all ones when nothing matched
    p_no_match_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 3'd1 || cyc_kind == 3'd2) && !dn_match && is_last
        |=> !oe || aa_value == ALL_ONES);

    // R7: a full chain keeps every device but the last off the bus
    p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_kind == 3'd3 && !dn_free_seen && !is_last |=> !aa_drive);

    // R9: a selected read shows the read address next cycle
    p_read_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_kind == 3'd4 && loc_sel |=> !oe || aa_value == $past(rd_addr));

    // R2: idle codes hold the output while the enable stays high
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 3'd0 || cyc_kind == 3'd6 || cyc_kind == 3'd7) && oe
        |=> !oe || $stable(aa_value));
endmodule

bind aab_arbiter aab_arbiter_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/aab_arbiter_test.sv
// Three-device chain bench with a scoreboard queue.
module aab_arbiter_test;
    localparam int W = 12;
    localparam int N = 3;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    typedef struct {
        logic [N-1:0] drv;
        logic [W-1:0] bus;
        logic         dnm;
        logic         dnf;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] kind = 3'd0;
    logic [N-1:0] lm = '0, lf = '0, ls = '0, oe = '1;
    logic [W-1:0] lma [N];
    logic [W-1:0] lfa [N];
    logic [W-1:0] rd = '0, wr = '0;
    logic [W-1:0] val [N];
    logic [N-1:0] drv;
    logic [N-1:0] dm, df;
    logic [W-1:0] bus;

    exp_t q[$];
    int n_cmp = 0, n_bad = 0;
    logic [N-1:0] msel = '0;
    logic [W-1:0] mval [N];

    always #2 clk = ~clk;

    aab_arbiter #(.ADDR_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_kind(kind),
        .loc_match(lm[0]), .loc_match_addr(lma[0]), .loc_full(lf[0]),
        .loc_free_addr(lfa[0]), .loc_sel(ls[0]), .rd_addr(rd), .wr_addr(wr),
        .up_match(1'b0), .up_free_seen(1'b0), .is_last(1'b0), .oe(oe[0]),
        .aa_value(val[0]), .aa_drive(drv[0]), .dn_match(dm[0]), .dn_free_seen(df[0]));
    aab_arbiter #(.ADDR_W(W)) dev1 (
        .clk(clk), .rst_n(rst_n), .cyc_kind(kind),
        .loc_match(lm[1]), .loc_match_addr(lma[1]), .loc_full(lf[1]),
        .loc_free_addr(lfa[1]), .loc_sel(ls[1]), .rd_addr(rd), .wr_addr(wr),
        .up_match(dm[0]), .up_free_seen(df[0]), .is_last(1'b0), .oe(oe[1]),
        .aa_value(val[1]), .aa_drive(drv[1]), .dn_match(dm[1]), .dn_free_seen(df[1]));
    aab_arbiter #(.ADDR_W(W)) dev2 (
        .clk(clk), .rst_n(rst_n), .cyc_kind(kind),
        .loc_match(lm[2]), .loc_match_addr(lma[2]), .loc_full(lf[2]),
        .loc_free_addr(lfa[2]), .loc_sel(ls[2]), .rd_addr(rd), .wr_addr(wr),
        .up_match(dm[1]), .up_free_seen(df[1]), .is_last(1'b1), .oe(oe[2]),
        .aa_value(val[2]), .aa_drive(drv[2]), .dn_match(dm[2]), .dn_free_seen(df[2]));

    assign bus = val[0] | val[1] | val[2];

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // Driver: apply one cycle at a negedge, push the expected result of the next edge.
    task automatic run_cycle(input logic [2:0] k, input string tag);
        exp_t e;
        int first;
        kind = k;
        if (k == 3'd1 || k == 3'd2) begin
            first = -1;
            for (int i = 0; i < N; i++) if (lm[i] && first < 0) first = i;
            msel = '0;
            if (first >= 0) begin msel[first] = 1'b1; mval[first] = lma[first]; end
            else begin msel[N-1] = 1'b1; mval[N-1] = ONES; end
        end else if (k == 3'd3) begin
            first = -1;
            for (int i = 0; i < N; i++) if (!lf[i] && first < 0) first = i;
            msel = '0;
            if (first >= 0) begin msel[first] = 1'b1; mval[first] = lfa[first]; end
            else begin msel[N-1] = 1'b1; mval[N-1] = ONES; end
        end else if (k == 3'd4 || k == 3'd5) begin
            msel = ls;
            for (int i = 0; i < N; i++) mval[i] = (k == 3'd4) ? rd : wr;
        end
        e.drv = msel & oe;
        e.bus = '0;
        for (int i = 0; i < N; i++) if (e.drv[i]) e.bus = e.bus | mval[i];
        e.dnm = |lm;
        e.dnf = |(~lf);
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                for (int i = 0; i < N; i++)
                    check($sformatf("%s drive dev%0d", e.tag, i), 32'(drv[i]), 32'(e.drv[i]));
                check({e.tag, " bus value"}, 32'(bus), 32'(e.bus));
                check({e.tag, " driver count"}, $countones(drv), $countones(e.drv));
                check({e.tag, " R10 chain match"}, 32'(dm[N-1]), 32'(e.dnm));
                check({e.tag, " R10 chain free"}, 32'(df[N-1]), 32'(e.dnf));
            end
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            lma[i] = W'(12'h100 + i * 12'h011);
            lfa[i] = W'(12'h200 + i * 12'h022);
            mval[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_cycle(3'd0, "R1 reset state");
        lm = 3'b010; run_cycle(3'd1, "R3 search dev1 wins");
        lm = 3'b101; run_cycle(3'd1, "R4 dev0 beats dev2");
        lm = 3'b000; run_cycle(3'd1, "R5 no match ones");
        lm = 3'b110; run_cycle(3'd2, "R3 R4 hp access");
        lm = 3'b001; lma[0] = 12'hABC; run_cycle(3'd0, "R2 code 0 holds");
        run_cycle(3'd7, "R2 code 7 holds");
        oe = 3'b101; run_cycle(3'd6, "R8 selected oe low");
        oe = 3'b111; run_cycle(3'd0, "R8 oe back");
        lm = 3'b000; oe = 3'b011; run_cycle(3'd1, "R8 last oe low no drive");
        oe = 3'b111;
        lf = 3'b001; run_cycle(3'd3, "R6 dev1 first free");
        lf = 3'b000; run_cycle(3'd3, "R6 dev0 free");
        lf = 3'b011; run_cycle(3'd3, "R6 dev2 free");
        lf = 3'b111; run_cycle(3'd3, "R7 full ones");
        rd = 12'h3C5; ls = 3'b100; run_cycle(3'd4, "R9 read dev2");
        wr = 12'h5A7; ls = 3'b001; run_cycle(3'd5, "R9 write dev0");
        ls = 3'b000; run_cycle(3'd4, "R9 read no select");
        oe = 3'b000; ls = 3'b010; run_cycle(3'd5, "R8 write oe low");
        oe = 3'b111; run_cycle(3'd0, "R8 write oe high");
        kind = 3'd0;
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #20000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule